// File: doc/BRIEF.md
# Asymmetric Byte Mailbox Between Two Processor Buses

This block joins a host processor bus and a coprocessor bus with a pair of one-way byte channels. Each side sees a two-register window: a status register at offset 0 and a data register at offset 1. Bytes the coprocessor writes go into a FIFO deep enough to hold a whole multi-byte display command, and the host drains them in order. Bytes the host writes go into a single-byte holding register. Filling that register raises an interrupt request toward the coprocessor.

In each status register, bit 7 means "something waiting for you to read" and bit 6 means "room for you to write". On the coprocessor side, bit 7 is the same flag that drives the interrupt. Reading the holding register from the coprocessor side empties it and drops the interrupt. Both sides share one clock and use single-cycle read and write strobes. Read data is registered and appears one cycle after the strobe.

Top module: `mbx_bridge`

## Requirements
- R1: After the synchronous active-high reset, both paths are empty, `c_irq` is low, both read-data outputs are 0x00, and both status registers read 0x40.
- R2: A coprocessor write to offset 1 pushes a byte. Host reads of offset 1 return the pushed bytes in first-in first-out order, one clock after the read strobe.
- R3: The coprocessor-to-host path holds FIFO_DEPTH (default 10) bytes. Coprocessor status bit 6 is 1 while fewer are held and 0 when it is full. Host status bit 7 is 1 while at least one byte is held.
- R4: A coprocessor write to the data register while the FIFO is full is dropped, and the stored bytes are unchanged.
- R5: A host data read while the FIFO is empty returns the byte most recently popped (0x00 if none) and leaves the FIFO empty.
- R6: A host write to offset 1 while the holding register is empty stores the byte. From the next cycle `c_irq` is 1, host status bit 6 is 0, and coprocessor status bit 7 is 1.
- R7: A coprocessor read of offset 1 while the holding register is full returns the stored byte and clears `c_irq` and the full flag.
- R8: A host write to offset 1 while the holding register is full is dropped, and the stored byte is kept.
- R9: A coprocessor read of offset 1 while the holding register is empty returns its last byte and leaves `c_irq` low.
- R10: Status bits 5:0 read as zero on both sides. Writes to offset 0 have no effect.
- R11: A push and a pop on a non-empty, non-full FIFO in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 1 | Host register offset (0 status, 1 data) |
| h_wr | input | 1 | Host single-cycle write strobe |
| h_rd | input | 1 | Host single-cycle read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host registered read data |
| c_addr | input | 1 | Coprocessor register offset (0 status, 1 data) |
| c_wr | input | 1 | Coprocessor single-cycle write strobe |
| c_rd | input | 1 | Coprocessor single-cycle read strobe |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor registered read data |
| c_irq | output | 1 | Interrupt request to the coprocessor while the holding register is full |

## Verification
The FIFO is exercised in three ways:
- A short burst of distinct bytes, which separates correct ordering from reversed or stale reads.
- A fill to exactly the depth followed by one extra write. This exposes an off-by-one limit and an overwrite on full.
- An overlapped push and pop, which shows whether a simultaneous access is lost.

The holding register is exercised by:
- A write, then a second write while it is full. This shows whether a full register is overwritten.
- Two reads in a row. This shows whether the interrupt is cleared by a read and never set by a read of an empty register.

Status writes and empty reads test that those accesses leave the state unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned STAT_AVAIL_BIT = 7;
  localparam int unsigned STAT_ROOM_BIT  = 6;
  localparam logic        OFS_STATUS     = 1'b0;
  localparam logic        OFS_DATA       = 1'b1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] last_q;
  logic              push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) begin
        rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_latch.sv
module mbx_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              rd,
  output logic [DATA_W-1:0] dout,
  output logic              full
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (full_q) begin
      if (rd) full_q <= 1'b0;
    end else if (wr) begin
      data_q <= din;
      full_q <= 1'b1;
    end
  end

  assign dout = data_q;
  assign full = full_q;
endmodule

// File: rtl/mbx_readport.sv
module mbx_readport #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              sel_data,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel_data ? data : status;
  end
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              c_addr,
  input  logic              c_wr,
  input  logic              c_rd,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic              c_irq
);
  logic              h_data_sel, c_data_sel;
  logic [DATA_W-1:0] up_head, dn_data;
  logic              up_empty, up_full, dn_full;
  logic [DATA_W-1:0] h_stat, c_stat;

  assign h_data_sel = (h_addr == OFS_DATA);
  assign c_data_sel = (c_addr == OFS_DATA);

  mbx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_up (
    .clk(clk), .rst(rst),
    .push(c_wr && c_data_sel), .din(c_wdata),
    .pop(h_rd && h_data_sel), .head(up_head),
    .empty(up_empty), .full(up_full)
  );

  mbx_latch #(.DATA_W(DATA_W)) u_dn (
    .clk(clk), .rst(rst),
    .wr(h_wr && h_data_sel), .din(h_wdata),
    .rd(c_rd && c_data_sel), .dout(dn_data), .full(dn_full)
  );

  always_comb begin
    h_stat = '0;
    h_stat[STAT_AVAIL_BIT] = !up_empty;
    h_stat[STAT_ROOM_BIT]  = !dn_full;
    c_stat = '0;
    c_stat[STAT_AVAIL_BIT] = dn_full;
    c_stat[STAT_ROOM_BIT]  = !up_full;
  end

  mbx_readport #(.DATA_W(DATA_W)) u_h_rp (
    .clk(clk), .rst(rst), .rd(h_rd), .sel_data(h_data_sel),
    .status(h_stat), .data(up_head), .rdata(h_rdata)
  );

  mbx_readport #(.DATA_W(DATA_W)) u_c_rp (
    .clk(clk), .rst(rst), .rd(c_rd), .sel_data(c_data_sel),
    .status(c_stat), .data(dn_data), .rdata(c_rdata)
  );

  assign c_irq = dn_full;
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              h_addr,
  input logic              h_wr,
  input logic              h_rd,
  input logic [DATA_W-1:0] h_rdata,
  input logic              c_addr,
  input logic              c_rd,
  input logic [DATA_W-1:0] c_rdata,
  input logic              c_irq
);
  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (h_wr && h_addr && !c_irq) |=> c_irq);

  p_stat_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (c_rd && !c_addr) |=> (c_rdata[7] == $past(c_irq)));

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_addr && c_irq) |=> !c_irq);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (c_irq && !(c_rd && c_addr)) |=> c_irq);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!c_irq && !(h_wr && h_addr)) |=> !c_irq);

  p_h_low_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (h_rd && !h_addr) |=> (h_rdata[5:0] == 6'd0));

  p_c_low_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (c_rd && !c_addr) |=> (c_rdata[5:0] == 6'd0));
endmodule

bind mbx_bridge mbx_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
  .h_rdata(h_rdata), .c_addr(c_addr), .c_rd(c_rd), .c_rdata(c_rdata),
  .c_irq(c_irq)
);

// File: tb/mbx_bridge_bench.sv
`timescale 1ns/1ps
module mbx_bridge_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       h_addr = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic       c_addr = 1'b0, c_wr = 1'b0, c_rd = 1'b0;
  logic [7:0] c_wdata = '0;
  logic [7:0] c_rdata;
  logic       c_irq;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  mbx_bridge u_mbx_bridge (
    .clk(clk), .rst(rst),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .c_irq(c_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-bench FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic h_access(input logic wr, input logic addr, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    h_addr = addr; h_wr = wr; h_rd = !wr; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0; h_rd = 1'b0;
    q = h_rdata;
  endtask

  task automatic c_access(input logic wr, input logic addr, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    c_addr = addr; c_wr = wr; c_rd = !wr; c_wdata = d;
    @(negedge clk);
    c_wr = 1'b0; c_rd = 1'b0;
    q = c_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R1 host rdata", h_rdata, 8'h00);
    chk("R1 irq", {7'd0, c_irq}, 8'h00);
    h_access(1'b0, 1'b0, 8'h00, q); chk("R1 host status", q, 8'h40);
    c_access(1'b0, 1'b0, 8'h00, q); chk("R1 copro status", q, 8'h40);
  endtask

  task automatic t_fifo_order();
    logic [7:0] q;
    c_access(1'b1, 1'b1, 8'hA1, q);
    c_access(1'b1, 1'b1, 8'hB2, q);
    c_access(1'b1, 1'b1, 8'hC3, q);
    h_access(1'b0, 1'b0, 8'h00, q); chk("R3 host status nonempty", q, 8'hC0);
    h_access(1'b0, 1'b1, 8'h00, q); chk("R2 order 0", q, 8'hA1);
    h_access(1'b0, 1'b1, 8'h00, q); chk("R2 order 1", q, 8'hB2);
    h_access(1'b0, 1'b1, 8'h00, q); chk("R2 order 2", q, 8'hC3);
  endtask

  task automatic t_fifo_full();
    logic [7:0] q;
    for (int i = 0; i < 10; i++) begin
      c_access(1'b0, 1'b0, 8'h00, q); chk("R3 room before full", q & 8'h40, 8'h40);
      c_access(1'b1, 1'b1, 8'(i * 7 + 1), q);
    end
    c_access(1'b0, 1'b0, 8'h00, q); chk("R3 copro status full", q, 8'h00);
    c_access(1'b1, 1'b1, 8'hEE, q);
    for (int i = 0; i < 10; i++) begin
      h_access(1'b0, 1'b1, 8'h00, q); chk("R4 stored byte kept", q, 8'(i * 7 + 1));
    end
    h_access(1'b0, 1'b1, 8'h00, q); chk("R4 overflow dropped / R5 empty read", q, 8'd64);
    h_access(1'b0, 1'b0, 8'h00, q); chk("R5 still empty", q, 8'h40);
  endtask

  task automatic t_latch();
    logic [7:0] q;
    h_access(1'b1, 1'b1, 8'h5A, q);
    chk("R6 irq set", {7'd0, c_irq}, 8'h01);
    h_access(1'b0, 1'b0, 8'h00, q); chk("R6 host status", q, 8'h00);
    c_access(1'b0, 1'b0, 8'h00, q); chk("R6 copro status", q, 8'hC0);
    h_access(1'b1, 1'b1, 8'h33, q);
    c_access(1'b0, 1'b1, 8'h00, q); chk("R7 R8 latched byte", q, 8'h5A);
    chk("R7 irq cleared", {7'd0, c_irq}, 8'h00);
    c_access(1'b0, 1'b1, 8'h00, q); chk("R9 empty read", q, 8'h5A);
    chk("R9 irq low", {7'd0, c_irq}, 8'h00);
  endtask

  task automatic t_status_writes();
    logic [7:0] q;
    h_access(1'b1, 1'b0, 8'hFF, q);
    c_access(1'b1, 1'b0, 8'hFF, q);
    chk("R10 irq unchanged", {7'd0, c_irq}, 8'h00);
    h_access(1'b0, 1'b0, 8'h00, q); chk("R10 host status", q, 8'h40);
    c_access(1'b0, 1'b0, 8'h00, q); chk("R10 copro status", q, 8'h40);
  endtask

  task automatic t_overlap();
    logic [7:0] q;
    c_access(1'b1, 1'b1, 8'h11, q);
    c_access(1'b1, 1'b1, 8'h22, q);
    @(negedge clk);
    c_addr = 1'b1; c_wr = 1'b1; c_wdata = 8'h33;
    h_addr = 1'b1; h_rd = 1'b1;
    @(negedge clk);
    c_wr = 1'b0; h_rd = 1'b0;
    chk("R11 pop during push", h_rdata, 8'h11);
    h_access(1'b0, 1'b1, 8'h00, q); chk("R11 next", q, 8'h22);
    h_access(1'b0, 1'b1, 8'h00, q); chk("R11 pushed kept", q, 8'h33);
    h_access(1'b0, 1'b0, 8'h00, q); chk("R11 drained", q, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fifo_order();
    t_fifo_full();
    t_latch();
    t_status_writes();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule